// File: doc/BRIEF.md
# DRAM rank boundary address decoder

This block turns a physical address into the number of the DRAM rank that holds it, for a memory system with two channels of four ranks each. Software loads eight cumulative rank-boundary registers and four rank-attribute registers over a simple write port. Each boundary counts in 32 MiB units. The block compares the address against these boundaries and reports which rank covers it, and whether any rank does. The result is registered, so it appears one clock after the address.

The block also decides on its own whether the two channels are interleaved. They are interleaved when the channel 0 and channel 1 boundaries agree pairwise and their page-size attribute fields also agree. In that case only the four channel 0 boundaries take part in the lookup, each counted twice as large. Otherwise the eight boundaries are read as one continuous sequence of ranks. The interleave flag follows the register contents directly. It changes in the cycle after the write that alters them.

Top module: `rank_addr_decoder`

## Requirements
- R1: After reset, rank_hit is 0 and rank_idx is 0. All configuration registers are zero, so the channels match and interleaved is 1.
- R2: A write with cfg_we high and cfg_sel 0..3 loads the channel 0 boundary of ranks 0..3, and cfg_sel 4..7 loads the channel 1 boundary of ranks 0..3. cfg_sel 8 and 9 load the channel 0 attributes for ranks 0/1 and 2/3, and 10 and 11 load the channel 1 attributes for the same pairs. A write with cfg_sel 12..15 changes nothing.
- R3: In an attribute register, bits 2:0 hold the even rank's page code and bits 6:4 hold the odd rank's code (000 empty, 010 4 KB, 011 8 KB, 100 16 KB, other codes reserved). Bits 7 and 3 are not compared.
- R4: interleaved is 1 exactly when all four channel 0 boundaries equal the matching channel 1 boundaries and all attribute fields of both channels agree. The flag takes its new value from the clock edge that performs the write.
- R5: When not interleaved, take u = addr[33:25] and boundaries B0..B7 in cfg_sel order. Rank k matches when B(k-1) <= u < Bk, with B(-1) = 0, and rank_idx is k.
- R6: When interleaved, only ranks 0..3 can match, with boundaries 2 x (channel 0 boundary k), up to 510 units. The channel 1 boundaries are ignored, and ranks 4..7 never match.
- R7: A rank whose boundary equals the one before it is empty and never matches. When more than one rank matches (boundaries out of order), the lowest index wins.
- R8: An address that no rank matches, including any at or above the last boundary, gives rank_hit 0 and rank_idx 0.
- R9: rank_idx and rank_hit give the decode of the addr value and the configuration present at the previous rising clock edge. Back-to-back addresses give back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| addr | input | 34 | Physical address to decode |
| rank_idx | output | 3 | Registered matching rank index |
| rank_hit | output | 1 | Registered match flag |
| interleaved | output | 1 | Channels count as interleaved |

## Verification
The bench loads a layout that contains an empty rank and probes addresses one unit on each side of every boundary. A decoder with an off-by-one comparison would report the neighbouring rank, and one that does not skip empty ranks would report rank 2 where rank 3 is right. It then makes the channels identical one register at a time, including attribute values that differ only in the reserved bits, so a compare that uses the wrong fields or the wrong bits flips the interleave flag at the wrong step. It also probes near the doubled top boundary of 510 units, where a decoder that is one bit too narrow would wrap and mis-decode. Out-of-order boundaries with overlapping ranges check that the lowest index wins, and a write to an unused select checks that no register is corrupted.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

  // Page-size field of the even rank in a pair
  function automatic logic [2:0] attr_even(input logic [7:0] a);
    return a[2:0];
  endfunction

  // Page-size field of the odd rank in a pair
  function automatic logic [2:0] attr_odd(input logic [7:0] a);
    return a[6:4];
  endfunction

  // Two attribute registers agree when both fields agree; reserved bits are ignored
  function automatic logic attr_pair_eq(input logic [7:0] a, input logic [7:0] b);
    return (attr_even(a) == attr_even(b)) && (attr_odd(a) == attr_odd(b));
  endfunction

endpackage

// File: rtl/rdec_cfg_regs.sv
module rdec_cfg_regs
  import rdec_pkg::*;
#(
  parameter int BND_W = 8,
  parameter int RPC   = 4,
  parameter int SEL_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [SEL_W-1:0]              cfg_sel,
  input  logic [BND_W-1:0]              cfg_wdata,
  output logic [2*RPC-1:0][BND_W-1:0]   bnd_q,
  output logic [RPC-1:0][7:0]           atr_q,
  output logic                          il
);
  localparam int NRANK = 2 * RPC;
  localparam int NATR  = RPC;      // RPC/2 pair registers per channel
  localparam int HALF  = RPC / 2;

  logic bnd_same;
  logic atr_same;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bnd_q <= '0;
      atr_q <= '0;
    end else if (cfg_we) begin
      for (int k = 0; k < NRANK; k++)
        if (cfg_sel == SEL_W'(k)) bnd_q[k] <= cfg_wdata;
      for (int a = 0; a < NATR; a++)
        if (cfg_sel == SEL_W'(NRANK + a)) atr_q[a] <= cfg_wdata[7:0];
    end
  end

  always_comb begin
    bnd_same = 1'b1;
    for (int k = 0; k < RPC; k++)
      if (bnd_q[k] != bnd_q[k+RPC]) bnd_same = 1'b0;
  end

  always_comb begin
    atr_same = 1'b1;
    for (int a = 0; a < HALF; a++)
      if (!attr_pair_eq(atr_q[a], atr_q[a+HALF])) atr_same = 1'b0;
  end

  assign il = bnd_same && atr_same;

  // R4: loading a channel 0 rank 0 boundary unlike its channel 1 partner ends interleaving
  p_bnd_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == SEL_W'(0) && cfg_wdata != bnd_q[RPC]) |=> !il);

  // R2: writes to unused selects leave every register unchanged
  p_rsvd_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel >= SEL_W'(NRANK + NATR)) |=> ($stable(bnd_q) && $stable(atr_q)));

endmodule

// File: rtl/rdec_bound_sel.sv
module rdec_bound_sel #(
  parameter int BND_W = 8,
  parameter int RPC   = 4
) (
  input  logic [2*RPC-1:0][BND_W-1:0] bnd_q,
  input  logic                        il,
  output logic [2*RPC-1:0][BND_W:0]   eff,
  output logic [2*RPC-1:0]            en
);
  localparam int NRANK = 2 * RPC;

  // Boundary in grain units, doubled when the channels interleave
  function automatic logic [BND_W:0] scale(input logic [BND_W-1:0] b, input logic dbl);
    return dbl ? {b, 1'b0} : {1'b0, b};
  endfunction

  for (genvar k = 0; k < NRANK; k++) begin : g_rank
    if (k < RPC) begin : g_ch0
      assign eff[k] = scale(bnd_q[k], il);
      assign en[k]  = 1'b1;
    end else begin : g_ch1
      assign eff[k] = il ? '0 : scale(bnd_q[k], 1'b0);
      assign en[k]  = !il;
    end
  end

endmodule

// File: rtl/rdec_match.sv
module rdec_match #(
  parameter int CMP_W = 9,
  parameter int EB_W  = 9,
  parameter int NRANK = 8,
  parameter int IDX_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [CMP_W-1:0]            unit,
  input  logic [NRANK-1:0][EB_W-1:0]  eff,
  input  logic [NRANK-1:0]            en,
  output logic [NRANK-1:0]            match,
  output logic                        hit,
  output logic [IDX_W-1:0]            idx
);
  logic [NRANK-1:0][CMP_W-1:0] lo;
  logic [NRANK-1:0][CMP_W-1:0] hi;

  for (genvar k = 0; k < NRANK; k++) begin : g_cmp
    if (k == 0) begin : g_first
      assign lo[k] = '0;
    end else begin : g_next
      assign lo[k] = CMP_W'(eff[k-1]);
      // R7: a rank with no span never reports a match
      p_empty_rank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eff[k] == eff[k-1]) |-> !match[k]);
    end
    assign hi[k]    = CMP_W'(eff[k]);
    assign match[k] = en[k] && (unit >= lo[k]) && (unit < hi[k]);
  end

  // Lowest matching rank wins
  always_comb begin
    hit = |match;
    idx = '0;
    for (int k = NRANK - 1; k >= 0; k--)
      if (match[k]) idx = IDX_W'(k);
  end

endmodule

// File: rtl/rank_addr_decoder.sv
module rank_addr_decoder #(
  parameter int ADDR_W   = 34,
  parameter int GRAIN_SH = 25,
  parameter int BND_W    = 8,
  parameter int RPC      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(3*RPC)-1:0]   cfg_sel,
  input  logic [BND_W-1:0]           cfg_wdata,
  input  logic [ADDR_W-1:0]          addr,
  output logic [$clog2(2*RPC)-1:0]   rank_idx,
  output logic                       rank_hit,
  output logic                       interleaved
);
  localparam int NRANK  = 2 * RPC;
  localparam int SEL_W  = $clog2(3 * RPC);
  localparam int IDX_W  = $clog2(NRANK);
  localparam int UNIT_W = ADDR_W - GRAIN_SH;
  localparam int EB_W   = BND_W + 1;
  localparam int CMP_W  = (UNIT_W > EB_W) ? UNIT_W : EB_W;

  logic [NRANK-1:0][BND_W-1:0] bnd_w;
  logic [RPC-1:0][7:0]         atr_w;
  logic                        il_w;
  logic [NRANK-1:0][EB_W-1:0]  eff_w;
  logic [NRANK-1:0]            en_w;
  logic [NRANK-1:0]            match_w;
  logic                        hit_c;
  logic [IDX_W-1:0]            idx_c;
  logic [CMP_W-1:0]            unit_c;
  logic                        addr_unused_lo;

  assign unit_c         = CMP_W'(addr[ADDR_W-1:GRAIN_SH]);
  assign addr_unused_lo = ^addr[GRAIN_SH-1:0];

  rdec_cfg_regs #(.BND_W(BND_W), .RPC(RPC), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .bnd_q(bnd_w), .atr_q(atr_w), .il(il_w)
  );

  rdec_bound_sel #(.BND_W(BND_W), .RPC(RPC)) u_bsel (
    .bnd_q(bnd_w), .il(il_w), .eff(eff_w), .en(en_w)
  );

  rdec_match #(.CMP_W(CMP_W), .EB_W(EB_W), .NRANK(NRANK), .IDX_W(IDX_W)) u_match (
    .clk(clk), .rst_n(rst_n), .unit(unit_c), .eff(eff_w), .en(en_w),
    .match(match_w), .hit(hit_c), .idx(idx_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_hit <= 1'b0;
      rank_idx <= '0;
    end else begin
      rank_hit <= hit_c;
      rank_idx <= idx_c;
    end
  end

  assign interleaved = il_w;

  // R8: a miss always reports rank zero
  p_miss_idx_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rank_hit |-> (rank_idx == '0));

  // R6: channel 1 ranks stay silent while interleaved
  p_ch1_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    interleaved |-> (match_w[NRANK-1:RPC] == '0));

endmodule

// File: tb/rank_addr_decoder_tb_top.sv
module rank_addr_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [33:0] addr = '0;
  logic [2:0]  rank_idx;
  logic        rank_hit;
  logic        interleaved;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rank_addr_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr(addr), .rank_idx(rank_idx),
    .rank_hit(rank_hit), .interleaved(interleaved)
  );

  // Bench model of the configuration
  logic [7:0] mb [8];
  logic [7:0] ma [4];

  function automatic bit model_il();
    bit s = 1;
    for (int k = 0; k < 4; k++) if (mb[k] != mb[k+4]) s = 0;
    for (int a = 0; a < 2; a++)
      if (ma[a][2:0] != ma[a+2][2:0] || ma[a][6:4] != ma[a+2][6:4]) s = 0;
    return s;
  endfunction

  function automatic int bound_of(int k, bit il);
    return il ? 2 * int'(mb[k]) : int'(mb[k]);
  endfunction

  // Scoreboard queues
  string      q_tag [$];
  logic [2:0] q_idx [$];
  logic       q_hit [$];
  int         ready_n = 0;

  task automatic check(string tag, int got, int exp, string what);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic probe(string tag, int u);
    bit il;
    int lim, lo, hi;
    logic [2:0] ei;
    logic eh;
    @(negedge clk);
    addr = {u[8:0], 25'h0ABCDE};
    il = model_il();
    lim = il ? 4 : 8;
    ei = '0; eh = 0;
    for (int k = 0; k < lim; k++) begin
      lo = (k == 0) ? 0 : bound_of(k - 1, il);
      hi = bound_of(k, il);
      if (!eh && u >= lo && u < hi) begin eh = 1; ei = 3'(k); end
    end
    q_tag.push_back(tag);
    q_idx.push_back(ei);
    q_hit.push_back(eh);
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = 8'(data);
    if (sel < 8) mb[sel] = 8'(data);
    else if (sel < 12) ma[sel-8] = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  always @(posedge clk) ready_n = q_hit.size();

  always @(negedge clk) begin
    if (ready_n > 0) begin
      string t;
      logic [2:0] ei;
      logic eh;
      t = q_tag.pop_front(); ei = q_idx.pop_front(); eh = q_hit.pop_front();
      check(t, int'(rank_hit), int'(eh), "rank_hit");
      check(t, int'(rank_idx), int'(ei), "rank_idx");
      ready_n = 0;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) mb[k] = '0;
    for (int a = 0; a < 4; a++) ma[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", int'(rank_hit), 0, "rank_hit after reset");
    check("R1", int'(rank_idx), 0, "rank_idx after reset");
    check("R1", int'(interleaved), 1, "interleaved after reset");
    probe("R8", 0);

    // Flat layout with empty rank 2
    wr(0, 4); wr(1, 8); wr(2, 8); wr(3, 12);
    wr(4, 16); wr(5, 20); wr(6, 24); wr(7, 32);
    check("R4", int'(interleaved), int'(model_il()), "interleaved flat");
    // R5 and R9: back-to-back probes around each boundary
    probe("R5", 0); probe("R5", 3); probe("R5", 4); probe("R5", 7);
    probe("R7", 8); probe("R7", 11); probe("R5", 12); probe("R5", 15);
    probe("R5", 16); probe("R5", 23); probe("R9", 24); probe("R5", 31);
    probe("R8", 32); probe("R8", 300);

    // Make channel 1 match channel 0
    wr(4, 4); wr(5, 8); wr(6, 8);
    check("R4", int'(interleaved), 0, "one boundary still differs");
    wr(7, 12);
    check("R4", int'(interleaved), 1, "boundaries equal");
    wr(8, 8'h32);
    check("R4", int'(interleaved), 0, "attribute differs");
    wr(10, 8'hBA);
    check("R3", int'(interleaved), 1, "reserved bits differ only");
    wr(11, 8'h04);
    check("R3", int'(interleaved), 0, "even field differs");
    wr(9, 8'h84);
    check("R3", int'(interleaved), 1, "even field equal again");

    // R6: doubled channel 0 boundaries 8,16,16,24
    probe("R6", 7); probe("R6", 8); probe("R6", 15); probe("R6", 16);
    probe("R6", 23); probe("R6", 24); probe("R6", 40);

    // R2: unused select is ignored
    wr(12, 8'hFF);
    check("R2", int'(interleaved), 1, "interleaved after unused select write");
    probe("R2", 8); probe("R2", 23); probe("R2", 24);

    // R7: out-of-order boundaries, lowest index wins
    wr(4, 2);
    check("R4", int'(interleaved), 0, "channel 1 rank 0 changed");
    probe("R7", 3); probe("R7", 5); probe("R7", 9); probe("R7", 12);

    // R6: top boundary doubled to 510
    wr(4, 4); wr(3, 255); wr(7, 255);
    check("R4", int'(interleaved), 1, "interleaved with top boundary 255");
    probe("R6", 16); probe("R6", 509); probe("R6", 510); probe("R6", 511);

    repeat (4) @(negedge clk);
    check("R9", q_hit.size(), 0, "scoreboard drained");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule